// File: doc/BRIEF.md
# Selectable-Tap Square Wave Prescaler

This block divides a slow timebase enable, one pulse per period of a 32.768 kHz reference, through a fifteen-stage synchronous binary counter. It drives a single square wave output from one counter stage chosen by a 4-bit rate code. Everything runs on one system clock. The timebase arrives as a one-cycle `tick` enable, so the counter advances only on cycles where `tick` is high and the output can change state only on those cycles. The exceptions are the gating and clear paths, which force the output low on the next clock.

Thirteen stages can be reached through the rate code. The output is forced low when the rate code is zero, when the enable input is low, or when the supply is reported as not good. A change of rate code or a return from the disabled state never produces a pulse shorter than half the new period. The output holds its level until the newly selected stage has an edge that agrees with that level, and from then on it follows the stage. A synchronous clear restarts the counter, so the first rising edge comes exactly one half-period after the clear.

Top module: `sqw_tap_divider`

## Requirements
- R1: While and after `rst_n` is low, `sq_out` is 0 and the counter is zero.
- R2: The counter advances by one only on clock cycles with `tick` high. With the output enabled and no clear, `sq_out` changes only on such cycles.
- R3: Rate code 1 selects stage 6, giving 256 Hz with a half-period of 64 ticks. Code 2 selects stage 7, giving 128 Hz with a half-period of 128 ticks. Code c from 3 to 15 selects stage c-2, giving a half-period of 2^(c-2) ticks: 8192 Hz at code 3 down to 2 Hz at code 15.
- R4: Once the output follows a stage, every high phase and every low phase lasts exactly the stage's half-period in ticks.
- R5: Rate code 0 holds `sq_out` at 0 from the next clock on.
- R6: `sq_en` low holds `sq_out` at 0 from the next clock on.
- R7: `power_ok` low holds `sq_out` at 0 from the next clock on.
- R8: `div_clr` high zeroes the counter and drives `sq_out` to 0 on the next clock. With the output enabled, the first rising edge follows after exactly one half-period of ticks.
- R9: After the code moves to a different stage, `sq_out` holds its level. At the first edge of the new stage whose resulting level equals the held level, the output starts to follow that stage, and it makes no edge at that point.
- R10: A code change between two codes that select the same stage (1 and 8, or 2 and 9) leaves the output edges unchanged.
- R11: When the output becomes enabled again, it stays low until a falling edge of the selected stage and rises one half-period after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase enable at the 32.768 kHz rate |
| div_clr | input | 1 | Synchronous clear of all divider stages |
| rate_sel | input | 4 | Rate code selecting the output stage |
| sq_en | input | 1 | Square wave output enable |
| power_ok | input | 1 | Supply-good status; low suppresses the output |
| sq_out | output | 1 | Square wave output, low when suppressed |

## Verification
The bench builds the block with its default values: fifteen stages and a 4-bit rate code. These are the values the fixed code map needs, and they bring the slowest tap (code 15, 8192-tick half-period) within reach. A tick on every clock lets that tap complete a full period in about 16k cycles, and runs with a tick on alternate cycles show that edges are counted in ticks rather than clocks. The fast taps at codes 3 to 5 and the mid taps at codes 1, 2, 8 and 9 are used for the rate-change, aliasing, gating and re-enable cases, where the edge positions depend on counter bits that the bench computes from the tick count.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
    localparam int SQW_STAGES     = 15;
    localparam int SQW_RATE_W     = 4;
    // Two low codes pick mid-range stages; the rest map linearly
    localparam int SQW_CODE_A     = 1;
    localparam int SQW_TAP_A      = 6;
    localparam int SQW_CODE_B     = 2;
    localparam int SQW_TAP_B      = 7;
    localparam int SQW_LINEAR_OFS = 2;
endpackage

// File: rtl/sqw_prescaler.sv
module sqw_prescaler #(
    parameter int STAGES = sqw_pkg::SQW_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clr,
    output logic [STAGES-1:0] cnt_q_o,
    output logic [STAGES-1:0] cnt_d_o
);
    typedef struct packed {
        logic [STAGES-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + STAGES'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q_o = st_q.cnt;
    assign cnt_d_o = st_d.cnt;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> (st_q.cnt == $past(st_q.cnt) + STAGES'(1))); // R2
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(st_q.cnt)); // R2
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0)); // R8
endmodule

// File: rtl/sqw_tap_mux.sv
module sqw_tap_mux #(
    parameter int  STAGES = sqw_pkg::SQW_STAGES,
    parameter int  RATE_W = sqw_pkg::SQW_RATE_W,
    localparam int IDX_W  = $clog2(STAGES)
) (
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [STAGES-1:0] cnt_q,
    input  logic [STAGES-1:0] cnt_d,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              sel_valid,
    output logic              bit_q,
    output logic              bit_d
);
    import sqw_pkg::*;

    always_comb begin
        sel_valid = (rate_sel != '0);
        if (!sel_valid) begin
            sel_idx = '0;
        end else if (rate_sel == RATE_W'(SQW_CODE_A)) begin
            sel_idx = IDX_W'(SQW_TAP_A);
        end else if (rate_sel == RATE_W'(SQW_CODE_B)) begin
            sel_idx = IDX_W'(SQW_TAP_B);
        end else begin
            sel_idx = IDX_W'(rate_sel) - IDX_W'(SQW_LINEAR_OFS);
        end
    end

    assign bit_q = cnt_q[sel_idx];
    assign bit_d = cnt_d[sel_idx];

    always_comb begin
        if (!$isunknown(rate_sel) && sel_valid) begin
            AST_TAP_RANGE: assert (int'(sel_idx) < STAGES - 1); // R3
        end
    end
endmodule

// File: rtl/sqw_out_ctrl.sv
module sqw_out_ctrl #(
    parameter int  STAGES = sqw_pkg::SQW_STAGES,
    localparam int IDX_W  = $clog2(STAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic             en_ok,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic             bit_q,
    input  logic             bit_d,
    output logic             sq_o
);
    typedef struct packed {
        logic [IDX_W-1:0] tap;
        logic             lock;
        logic             sq;
    } out_st_t;

    out_st_t st_d, st_q;
    logic    tap_edge;

    always_comb begin
        st_d     = st_q;
        tap_edge = tick && (bit_d != bit_q);
        if (!en_ok) begin
            st_d.sq   = 1'b0;
            st_d.lock = 1'b0;
            st_d.tap  = sel_idx;
        end else if (clr) begin
            st_d.sq   = 1'b0;
            st_d.lock = 1'b1;
            st_d.tap  = sel_idx;
        end else if (sel_idx != st_q.tap) begin
            st_d.lock = 1'b0;
            st_d.tap  = sel_idx;
        end else if (st_q.lock) begin
            st_d.sq = bit_d;
        end else if (tap_edge && (bit_d == st_q.sq)) begin
            st_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sq_o = st_q.sq;

    AST_LOCK_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock && (sel_idx == st_q.tap)) |-> (st_q.sq == bit_q)); // R4
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_ok && !tick && !clr) |=> $stable(st_q.sq)); // R2
    AST_UNLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_ok && !clr && !st_q.lock) |=> $stable(st_q.sq)); // R9
endmodule

// File: rtl/sqw_tap_divider.sv
module sqw_tap_divider #(
    parameter int  STAGES = sqw_pkg::SQW_STAGES,
    parameter int  RATE_W = sqw_pkg::SQW_RATE_W,
    localparam int IDX_W  = $clog2(STAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              div_clr,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              sq_en,
    input  logic              power_ok,
    output logic              sq_out
);
    logic [STAGES-1:0] cnt_q;
    logic [STAGES-1:0] cnt_d;
    logic [IDX_W-1:0]  sel_idx;
    logic              sel_valid;
    logic              bit_q;
    logic              bit_d;
    logic              en_ok;

    sqw_prescaler #(.STAGES(STAGES)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clr     (div_clr),
        .cnt_q_o (cnt_q),
        .cnt_d_o (cnt_d)
    );

    sqw_tap_mux #(.STAGES(STAGES), .RATE_W(RATE_W)) u_mux (
        .rate_sel  (rate_sel),
        .cnt_q     (cnt_q),
        .cnt_d     (cnt_d),
        .sel_idx   (sel_idx),
        .sel_valid (sel_valid),
        .bit_q     (bit_q),
        .bit_d     (bit_d)
    );

    assign en_ok = sq_en && power_ok && sel_valid;

    sqw_out_ctrl #(.STAGES(STAGES)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clr     (div_clr),
        .en_ok   (en_ok),
        .sel_idx (sel_idx),
        .bit_q   (bit_q),
        .bit_d   (bit_d),
        .sq_o    (sq_out)
    );

    AST_CODE0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |=> !sq_out); // R5
    AST_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_en |=> !sq_out); // R6
    AST_PWR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !power_ok |=> !sq_out); // R7
    AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        div_clr |=> !sq_out); // R8
endmodule

// File: tb/sqw_tap_divider_tb.sv
`timescale 1ns/1ps
module sqw_tap_divider_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       div_clr = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       sq_en = 1'b0;
    logic       power_ok = 1'b1;
    logic       sq_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    t;
        bit    lv;
        string req;
    } exp_t;
    exp_t  expq[$];
    string cur_req = "R1";

    // bench-side expectation state, derived from the requirements
    int tcount = 0;
    bit m_en = 1'b0;
    bit m_lock = 1'b0;
    bit m_lvl = 1'b0;
    int m_k = 0;

    always #4 clk = ~clk;

    sqw_tap_divider dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .div_clr  (div_clr),
        .rate_sel (rate_sel),
        .sq_en    (sq_en),
        .power_ok (power_ok),
        .sq_out   (sq_out)
    );

    function automatic int stage_of(int code);
        if (code == 1) return 6;   // R3
        if (code == 2) return 7;   // R3
        return code - 2;           // R3
    endfunction

    function automatic void push(int t, bit lv);
        exp_t e;
        e.t = t;
        e.lv = lv;
        e.req = cur_req;
        expq.push_back(e);
    endfunction

    function automatic void model_ctrl(int code, bit en, bit pok);
        bit newen;
        int newk;
        newen = en && pok && (code != 0);
        newk = stage_of(code);
        if (!newen) begin
            if (m_lvl) push(tcount, 1'b0);
            m_lvl = 1'b0;
            m_lock = 1'b0;
        end else if (!m_en || newk != m_k) begin
            m_lock = 1'b0;
        end
        m_en = newen;
        m_k = newk;
    endfunction

    function automatic void model_tick();
        bit lv;
        if (!m_en) return;
        if (tcount % (1 << m_k) != 0) return;
        lv = ((tcount >> m_k) & 1) != 0;
        if (m_lock) begin
            if (lv != m_lvl) push(tcount, lv);
            m_lvl = lv;
        end else if (lv == m_lvl) begin
            m_lock = 1'b1;
        end
    endfunction

    task automatic set_ctrl(int code, bit en, bit pok, string req);
        @(negedge clk);
        tick = 1'b0;
        cur_req = req;
        rate_sel = 4'(code);
        sq_en = en;
        power_ok = pok;
        model_ctrl(code, en, pok);
    endtask

    task automatic clear_div(string req);
        @(negedge clk);
        tick = 1'b0;
        cur_req = req;
        div_clr = 1'b1;
        tcount = 0;
        if (m_lvl) push(0, 1'b0);
        m_lvl = 1'b0;
        m_lock = m_en;
        @(negedge clk);
        div_clr = 1'b0;
    endtask

    task automatic do_ticks(int n, bit gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            tcount++;
            model_tick();
            if (gap) begin
                @(negedge clk);
                tick = 1'b0;
            end
        end
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic check_level(bit exp, string req);
        checks++;
        if (sq_out !== exp) begin
            errors++;
            $display("FAIL %s: sq_out level actual=%b expected=%b", req, sq_out, exp);
        end
    endtask

    task automatic check_drained(string req);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL %s: missing edges actual=0 expected=%0d (next t=%0d)",
                     req, expq.size(), expq[0].t);
            expq.delete();
        end
    endtask

    // monitor: compare every output edge with the scoreboard
    logic prev_sq = 1'b0;
    always @(posedge clk) begin
        #1;
        if (rst_n && sq_out !== prev_sq) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected edge actual level=%b at tick %0d expected=no edge",
                         cur_req, sq_out, tcount);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (e.t != tcount || e.lv != sq_out) begin
                    errors++;
                    $display("FAIL %s: edge actual tick=%0d level=%b expected tick=%0d level=%b",
                             e.req, tcount, sq_out, e.t, e.lv);
                end
            end
            prev_sq = sq_out;
        end
    end

    task automatic run_all();
        // R1: reset state
        idle(3);
        check_level(1'b0, "R1");
        rst_n = 1'b1;
        idle(2);
        check_level(1'b0, "R1");

        // R3 R4 R8: fastest tap from a clear
        set_ctrl(3, 1'b1, 1'b1, "R8");
        clear_div("R8");
        check_level(1'b0, "R8");
        cur_req = "R4";
        do_ticks(20, 1'b0);
        check_drained("R4");

        // R3: code 1 -> 64-tick half period
        set_ctrl(1, 1'b1, 1'b1, "R3");
        clear_div("R3");
        do_ticks(256, 1'b0);
        check_drained("R3");

        // R3: code 2 -> 128-tick half period
        set_ctrl(2, 1'b1, 1'b1, "R3");
        clear_div("R3");
        do_ticks(256, 1'b0);
        check_drained("R3");

        // R3 R2: slowest tap, ticks on alternate cycles
        set_ctrl(15, 1'b1, 1'b1, "R2");
        clear_div("R2");
        do_ticks(16384, 1'b1);
        check_drained("R2");
        idle(20);
        check_drained("R2");

        // R5: code 0 keeps the output low
        set_ctrl(0, 1'b1, 1'b1, "R5");
        clear_div("R5");
        do_ticks(64, 1'b0);
        check_level(1'b0, "R5");
        check_drained("R5");

        // R6: enable low forces the output low mid-phase
        set_ctrl(4, 1'b1, 1'b1, "R6");
        clear_div("R6");
        do_ticks(6, 1'b0);
        check_level(1'b1, "R6");
        set_ctrl(4, 1'b0, 1'b1, "R6");
        idle(3);
        check_level(1'b0, "R6");
        do_ticks(16, 1'b0);
        check_level(1'b0, "R6");
        check_drained("R6");

        // R11: re-enable waits for a falling edge of the stage
        set_ctrl(4, 1'b1, 1'b1, "R11");
        do_ticks(20, 1'b0);
        check_drained("R11");

        // R7: power loss forces the output low
        cur_req = "R7";
        do_ticks(2, 1'b0);
        check_level(1'b1, "R7");
        set_ctrl(4, 1'b1, 1'b0, "R7");
        idle(2);
        check_level(1'b0, "R7");
        do_ticks(8, 1'b0);
        check_level(1'b0, "R7");
        set_ctrl(4, 1'b1, 1'b1, "R11");
        do_ticks(12, 1'b0);
        check_drained("R7");

        // R9: slower then faster stage, no short pulses
        set_ctrl(3, 1'b1, 1'b1, "R9");
        clear_div("R9");
        do_ticks(5, 1'b0);
        set_ctrl(5, 1'b1, 1'b1, "R9");
        do_ticks(35, 1'b0);
        check_level(1'b1, "R9");
        set_ctrl(3, 1'b1, 1'b1, "R9");
        do_ticks(10, 1'b0);
        check_drained("R9");

        // R10: aliased codes for the same stage
        set_ctrl(1, 1'b1, 1'b1, "R10");
        clear_div("R10");
        do_ticks(100, 1'b0);
        set_ctrl(8, 1'b1, 1'b1, "R10");
        do_ticks(100, 1'b0);
        set_ctrl(2, 1'b1, 1'b1, "R10");
        clear_div("R10");
        do_ticks(130, 1'b0);
        set_ctrl(9, 1'b1, 1'b1, "R10");
        do_ticks(130, 1'b0);
        check_drained("R10");
    endtask

    initial begin
        bit wd_fired;
        wd_fired = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd_fired = 1'b1;
            end
        join_any
        disable fork;
        if (wd_fired) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete actual=timeout expected=finish");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule